// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block turns a reference clock into the two timing strobes an enhanced 16550-style UART needs: a sample tick that paces the receive and transmit oversampling, and a bit tick that marks each bit period. The reference clock first passes through a fractional prescaler whose ratio is programmed in eighths. The prescaled pulse stream then feeds a divisor counter. The divisor output is counted down once more by a programmable oversampling count to form the bit tick.

The prescaler can be switched out by a control bit. When it is switched out, the reference clock reaches the divisor stage directly. The reset value of that control bit is the inverse of a strap input, so a board can start either in the plain divide-by-divisor mode or in the prescaled mode. Configuration arrives over a single-cycle write port: write enable, 3-bit address and 8-bit data. The address map is: 0 divisor low byte, 1 divisor high byte, 2 mode control, 3 prescaler ratio, 4 oversampling count. Writes to any other address change nothing. Any write to the divisor, prescaler or oversampling registers restarts every internal counter, so the next ticks follow the new settings.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, the prescaler enable (mode-control bit 7, visible on `presc_en`) equals the inverse of `clk_sel`, and `mode_flag` is 0. The other registers reset to: divisor 1, prescaler ratio 0x08, oversampling field 0. With `clk_sel` low this gives one sample tick per clock and one bit tick per 16 clocks.
- R2: With the prescaler enabled, the ratio register value P (an 8-bit value in units of 1/8) gives one prescaled pulse per P/8 reference clocks on average. For example, 0x20 divides by 4.
- R3: Fractional ratios are made with an accumulator. Every reference clock it adds 8. When the sum reaches or passes P, P is subtracted and a pulse is emitted. With P = 0x0C and divisor 2, every sample tick is 3 clocks after the previous one.
- R4: Ratio values below 0x08 behave exactly as 0x08, which divides by 1.
- R5: When mode-control bit 7 is clear, the divisor stage advances on every reference clock, whatever the ratio register holds.
- R6: The low 4 bits of the oversampling register give the sample ticks per bit tick. The value 0 means 16, and the values 4 to 15 are used as written.
- R7: Oversampling values 1, 2 and 3 behave as 4.
- R8: A divisor latch value N gives one sample tick per N prescaled pulses. The value 0 means 2^DIV_W pulses.
- R9: Every bit tick coincides with a sample tick. Between two bit ticks lie exactly the effective oversampling count of sample ticks.
- R10: Mode-control bit 6 is stored and shown on `mode_flag`. It has no effect on tick timing, and a write to mode control does not restart the counters.
- R11: A write to the divisor, prescaler or oversampling register restarts the counters. With the prescaler bypassed and new divisor N, the first sample tick appears N+1 clocks after the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_sel | input | 1 | Strap; its inverse is the reset value of the prescaler enable |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit-period strobe |
| presc_en | output | 1 | Current prescaler enable (mode-control bit 7) |
| mode_flag | output | 1 | Stored mode-control bit 6 |

## Verification
The bench builds the block with DIV_W = 8 and leaves every other parameter at its default. The narrow counter makes a divisor of 0 wrap to 256 pulses instead of 65536, so the full-range divisor case fits in a short run next to the fractional, clamped and bypassed prescaler cases. Each case is checked by measuring the periods of both ticks after the settings change, and by timing the first tick that follows a restart.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  // Register addresses on the write port
  typedef enum logic [2:0] {
    A_DIV_LO = 3'd0,
    A_DIV_HI = 3'd1,
    A_MCTL   = 3'd2,
    A_PRESC  = 3'd3,
    A_OVS    = 3'd4
  } reg_addr_e;

  localparam int unsigned PRESC_W     = 8;
  localparam int unsigned FRAC_BITS   = 3;
  localparam logic [PRESC_W-1:0] PRESC_UNITY = PRESC_W'(1 << FRAC_BITS);
  localparam int unsigned OVS_W       = 4;
  localparam int unsigned OVS_MIN     = 4;
  localparam int unsigned MCTL_PRE_B  = 7;
  localparam int unsigned MCTL_MODE_B = 6;

endpackage

// File: rtl/bg_frac_prescaler.sv
module bg_frac_prescaler
  import baudgen_pkg::*;
#(
  parameter int unsigned PW = PRESC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [PW-1:0] ratio,
  output logic          tick
);

  localparam int unsigned AW = PW + 1;

  logic [PW-1:0] ratio_eff;
  logic [AW-1:0] acc_q, acc_d, sum;
  logic          pulse_q, pulse_d;

  // values under unity are raised to unity (divide by one)
  assign ratio_eff = (ratio < PW'(PRESC_UNITY)) ? PW'(PRESC_UNITY) : ratio;

  always_comb begin
    sum     = acc_q + AW'(PRESC_UNITY);
    acc_d   = acc_q;
    pulse_d = 1'b0;
    if (clr) begin
      acc_d = '0;
    end else if (en) begin
      if (sum >= {1'b0, ratio_eff}) begin
        acc_d   = sum - {1'b0, ratio_eff};
        pulse_d = 1'b1;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      pulse_q <= pulse_d;
    end
  end

  // bypass passes the reference clock straight through
  assign tick = en ? pulse_q : 1'b1;

  // R3, R4: remainder left after an update stays below the ratio in force
  a_r3_acc_below_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (acc_q < {1'b0, $past(ratio_eff)}));

endmodule

// File: rtl/bg_divisor_count.sv
module bg_divisor_count #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [DW-1:0] divisor,
  output logic          tick
);

  logic [DW-1:0] load;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  // zero wraps to all ones, giving 2^DW steps per tick
  assign load = divisor - DW'(1);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (clr) begin
      cnt_d = load;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_d  = load;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R8: a step at terminal count yields a tick next cycle
  a_r8_terminal_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && cnt_q == '0) |=> tick_q);

  // R8: no tick without a step
  a_r8_no_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!step || clr) |=> !tick_q);

endmodule

// File: rtl/bg_oversample.sv
module bg_oversample
  import baudgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sample,
  input  logic [OVS_W-1:0] ovs,
  output logic             bit_tick
);

  localparam int unsigned EW = OVS_W + 1;

  logic [EW-1:0]    os_eff;
  logic [OVS_W-1:0] load;
  logic [OVS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (ovs == '0)
      os_eff = EW'(1 << OVS_W);
    else if (ovs < OVS_W'(OVS_MIN))
      os_eff = EW'(OVS_MIN);
    else
      os_eff = EW'(ovs);
  end

  assign load     = OVS_W'(os_eff - EW'(1));
  assign bit_tick = sample && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = load;
    else if (sample)
      cnt_d = (cnt_q == '0) ? load : cnt_q - OVS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6, R7: effective count always in 4..16
  a_r7_os_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (os_eff >= EW'(OVS_MIN)) && (os_eff <= EW'(1 << OVS_W)));

  // R9: counter only moves on sample ticks or restarts
  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baudgen_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_sel,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       sample_tick,
  output logic       bit_tick,
  output logic       presc_en,
  output logic       mode_flag
);

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FULL_W = 2 * BYTE_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // register file
  logic [DIV_W-1:0]   div_q, div_d;
  logic [FULL_W-1:0]  div_full, div_full_d;
  logic [PRESC_W-1:0] presc_q;
  logic [OVS_W-1:0]   ovs_q;
  logic               pre_en_q, mode_q;
  logic               we_div_lo, we_div_hi, we_mctl, we_presc, we_ovs;
  logic               we_div, clr_d, clr_q;

  assign we_div_lo = wr_en && (wr_addr == A_DIV_LO);
  assign we_div_hi = wr_en && (wr_addr == A_DIV_HI);
  assign we_mctl   = wr_en && (wr_addr == A_MCTL);
  assign we_presc  = wr_en && (wr_addr == A_PRESC);
  assign we_ovs    = wr_en && (wr_addr == A_OVS);
  assign we_div    = we_div_lo || we_div_hi;
  assign clr_d     = we_div || we_presc || we_ovs;

  assign div_full = FULL_W'(div_q);

  always_comb begin
    div_full_d = div_full;
    if (we_div_lo) div_full_d = {div_full[FULL_W-1:BYTE_W], wr_data};
    if (we_div_hi) div_full_d = {wr_data, div_full[BYTE_W-1:0]};
    div_d = div_full_d[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      div_q    <= DIV_W'(1);
      presc_q  <= PRESC_UNITY;
      ovs_q    <= '0;
      pre_en_q <= ~clk_sel;
      mode_q   <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      if (we_div)   div_q   <= div_d;
      if (we_presc) presc_q <= wr_data;
      if (we_ovs)   ovs_q   <= wr_data[OVS_W-1:0];
      if (we_mctl) begin
        pre_en_q <= wr_data[MCTL_PRE_B];
        mode_q   <= wr_data[MCTL_MODE_B];
      end
      clr_q <= clr_d;
    end
  end

  // datapath
  logic pre_tick;
  logic samp;

  bg_frac_prescaler #(.PW(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (pre_en_q),
    .clr   (clr_q),
    .ratio (presc_q),
    .tick  (pre_tick)
  );

  bg_divisor_count #(.DW(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_i),
    .clr     (clr_q),
    .step    (pre_tick),
    .divisor (div_q),
    .tick    (samp)
  );

  bg_oversample u_ovs (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr      (clr_q),
    .sample   (samp),
    .ovs      (ovs_q),
    .bit_tick (bit_tick)
  );

  assign sample_tick = samp;
  assign presc_en    = pre_en_q;
  assign mode_flag   = mode_q;

  // R9: a bit tick never stands alone
  a_r9_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_i)
    bit_tick |-> sample_tick);

  // R5: bypassed prescaler steps the divisor every clock
  a_r5_bypass_every_clock: assert property (@(posedge clk) disable iff (!rst_i)
    !pre_en_q |-> pre_tick);

  // R11: restart suppresses any stale sample tick
  a_r11_restart_quiet: assert property (@(posedge clk) disable iff (!rst_i)
    clr_q |=> !sample_tick);

  // R10: mode-control writes leave the counters running
  a_r10_mctl_no_restart: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && wr_addr == A_MCTL) |=> !clr_q);

endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sample_tick, bit_tick, presc_en, mode_flag;

  always #10 clk = ~clk;  // 50 MHz

  frac_baud_gen #(.DIV_W(8)) u_frac_baud_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_sel     (clk_sel),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .presc_en    (presc_en),
    .mode_flag   (mode_flag)
  );

  typedef struct {
    int    samp;
    int    bitp;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   skip = 1'b1;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] mctl, input logic [7:0] presc,
                     input logic [7:0] ovs, input logic [7:0] div);
    wr(3'd2, mctl);
    wr(3'd3, presc);
    wr(3'd4, ovs);
    wr(3'd0, div);
    wr(3'd1, 8'h00);
  endtask

  // driver: push expected periods, wait for the monitor to drain them
  task automatic expect_run(input int samp, input int bitp, input string tag);
    @(posedge clk); #1;
    skip = 1'b1;
    for (int i = 0; i < 3; i++) q.push_back('{samp, bitp, tag});
    wait (q.size() == 0);
  endtask

  // monitor: measure tick intervals, compare against the queue
  int since_bit = 0;
  int since_samp = 0;
  int samp_meas = 0;
  always @(negedge clk) begin
    since_bit++;
    since_samp++;
    if (sample_tick) begin
      samp_meas = since_samp;
      since_samp = 0;
    end
    if (bit_tick) begin
      if (q.size() != 0) begin
        if (skip) begin
          skip = 1'b0;
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(since_bit == e.bitp, e.tag, "bit period", since_bit, e.bitp);
          chk(samp_meas == e.samp, e.tag, "sample period", samp_meas, e.samp);
          // R9: coincidence of the two strobes
          chk(sample_tick == 1'b1, "R9", "sample with bit", int'(sample_tick), 1);
        end
      end
      since_bit = 0;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL all: watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state with strap low
    chk(presc_en == 1'b1, "R1", "presc_en after reset", int'(presc_en), 1);
    chk(mode_flag == 1'b0, "R1", "mode_flag after reset", int'(mode_flag), 0);
    expect_run(1, 16, "R1");

    // R5, R6: bypass, divisor 5, oversampling 0 -> 16
    cfg(8'h00, 8'h20, 8'h00, 8'd5);
    expect_run(5, 80, "R5");

    // R2: ratio 0x20 divides by 4, divisor 3, oversampling 8
    cfg(8'h80, 8'h20, 8'h08, 8'd3);
    expect_run(12, 96, "R2");

    // R3: ratio 1.5, divisor 2, oversampling 4
    cfg(8'h80, 8'h0C, 8'h04, 8'd2);
    expect_run(3, 12, "R3");

    // R4: ratio below unity behaves as unity
    cfg(8'h80, 8'h03, 8'h05, 8'd4);
    expect_run(4, 20, "R4");

    // R7: oversampling 2 behaves as 4
    cfg(8'h80, 8'h08, 8'h02, 8'd2);
    expect_run(2, 8, "R7");

    // R6: oversampling 15 used literally, upper nibble ignored
    cfg(8'h80, 8'h08, 8'hFF, 8'd2);
    expect_run(2, 30, "R6");

    // R10: mode flag stored, timing unchanged
    cfg(8'hC0, 8'h10, 8'h04, 8'd2);
    chk(mode_flag == 1'b1, "R10", "mode_flag set", int'(mode_flag), 1);
    chk(presc_en == 1'b1, "R10", "presc_en kept", int'(presc_en), 1);
    expect_run(4, 16, "R10");

    // R8: divisor 0 wraps to 256 with an 8-bit counter
    cfg(8'h00, 8'h08, 8'h04, 8'd0);
    expect_run(256, 1024, "R8");

    // R11: restart latency after a divisor write
    cfg(8'h00, 8'h08, 8'h04, 8'd200);
    repeat (50) @(negedge clk);
    wr(3'd0, 8'd3);
    begin
      int n = 0;
      for (int i = 0; i < 300; i++) begin
        @(posedge clk);
        n++;
        @(negedge clk);
        if (sample_tick) break;
      end
      chk(n == 4, "R11", "clocks to first tick", n, 4);
    end

    // R1: strap high starts with the prescaler bypassed
    @(negedge clk);
    rst_n = 1'b0;
    clk_sel = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(presc_en == 1'b0, "R1", "presc_en with strap high", int'(presc_en), 0);
    chk(mode_flag == 1'b0, "R1", "mode_flag with strap high", int'(mode_flag), 0);

    finish_up();
  end

endmodule